// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer on a simple single-cycle register bus. The bus has an address, a write strobe, 32-bit write data and 32-bit read data. The read data is combinational from the address. The timer has three registers: a control word, a reload value and a live 16-bit down-counter.

The counter advances on a slow tick. The tick comes from the peripheral clock in two stages: an 8-bit prescaler that divides by P+1, then a fixed divider of 16, 32, 64 or 128. When the counter is at zero on a tick, the block has expired. On expiry it refills the counter from the reload register and keeps counting. It can also start a fixed-length system reset pulse, raise a level interrupt, or both. Software keeps the system alive by rewriting the counter before it runs out.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset the register at offset 0x00 reads 0x00008021. The registers at offsets 0x04 and 0x08 read 0x00008000. The reset output and the interrupt output are low.
- R2: The control register holds these fields: bit 0 reset-enable, bit 2 interrupt-enable, bits [4:3] divider select, bit 5 run, bits [15:8] prescaler P. Every other bit reads 0. The reload register (0x04) and the counter (0x08) read back their low 16 bits, with the upper bits 0. Any unmapped offset reads 0.
- R3: While run is set, a tick occurs every (P+1)·D input-clock cycles. D is 16, 32, 64 or 128 for divider select 00, 01, 10 or 11.
- R4: On each tick the counter drops by one. A tick that finds the counter at 0 is an expiry: it loads the counter from the reload register.
- R5: A bus write to offset 0x08 loads its low 16 bits into the counter on the next clock edge. That write takes priority over a tick in the same cycle and clears the interrupt.
- R6: Every write to the control register restarts the prescaler and divider phase. The first tick after such a write comes a full (P+1)·D cycles later.
- R7: While run is clear, the counter and the tick phase do not advance. The prescaler and divider fields keep their written values.
- R8: An expiry with reset-enable set drives the reset output high for exactly 128 input-clock cycles, starting at the expiry's clock edge. A further expiry during the pulse starts the 128 cycles again.
- R9: An expiry with interrupt-enable set raises the interrupt output at the expiry's clock edge. The interrupt stays high until a counter write. With both enables clear, an expiry drives neither output.
- R10: If the counter is rewritten more often than every (reload+1) ticks, neither output ever asserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| sys_rst_o | output | 1 | System reset pulse |
| irq_o | output | 1 | Level interrupt on expiry |

## Verification
The assertions check the counter on every cycle:
- each tick moves it down by one or refills it from the reload register;
- it holds while stopped;
- a counter write loads it.

They also check that each rising edge of an output follows an enabled expiry. Further assertions check that the interrupt holds until a counter write clears it, and that every reset pulse lasts exactly 128 cycles.

Only the bench scenarios can show that the tick period matches (P+1)·D across the divider and prescaler settings. The same holds for the restart of the phase on a control write, the reset values, and field masking on readback. It also holds for the keep-alive pattern keeping both outputs quiet.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRE_W    = 8;
  localparam int DIVSEL_W = 2;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_RELOAD = 8'h04;
  localparam logic [7:0] OFF_COUNT  = 8'h08;

  localparam int B_RST_EN = 0;
  localparam int B_IRQ_EN = 2;
  localparam int B_DIV_LO = 3;
  localparam int B_RUN    = 5;
  localparam int B_PRE_LO = 8;

  typedef struct packed {
    logic [PRE_W-1:0]    pre;
    logic                run;
    logic [DIVSEL_W-1:0] div_sel;
    logic                irq_en;
    logic                rst_en;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.pre     = w[B_PRE_LO +: PRE_W];
    c.run     = w[B_RUN];
    c.div_sel = w[B_DIV_LO +: DIVSEL_W];
    c.irq_en  = w[B_IRQ_EN];
    c.rst_en  = w[B_RST_EN];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[B_PRE_LO +: PRE_W]    = c.pre;
    w[B_RUN]                = c.run;
    w[B_DIV_LO +: DIVSEL_W] = c.div_sel;
    w[B_IRQ_EN]             = c.irq_en;
    w[B_RST_EN]             = c.rst_en;
    return w;
  endfunction
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int PRE_W        = 8,
  parameter int DIVSEL_W     = 2,
  parameter int DIV_MIN_LOG2 = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                restart_i,
  input  logic [PRE_W-1:0]    pre_i,
  input  logic [DIVSEL_W-1:0] div_sel_i,
  output logic                tick_o
);
  localparam int DIVC_W = DIV_MIN_LOG2 + (1 << DIVSEL_W) - 1;

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [DIVC_W-1:0] div_q, div_d;
  logic [DIVC_W-1:0] div_lim;
  logic              pre_hit;

  // last phase value of the selected fixed divider
  always_comb begin
    div_lim = '0;
    for (int k = 0; k < (1 << DIVSEL_W); k++) begin
      if (div_sel_i == DIVSEL_W'(k))
        div_lim = DIVC_W'((1 << (DIV_MIN_LOG2 + k)) - 1);
    end
  end

  assign pre_hit = run_i && (pre_q == pre_i);
  assign tick_o  = pre_hit && (div_q == div_lim);

  always_comb begin
    pre_d = pre_q;
    div_d = div_q;
    if (restart_i || !run_i) begin
      pre_d = '0;
      div_d = '0;
    end else if (pre_hit) begin
      pre_d = '0;
      div_d = (div_q == div_lim) ? '0 : div_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] CNT_RST = 16'h8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = tick_i && !load_i && at_zero;
  assign cnt_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (tick_i)
      cnt_d = at_zero ? reload_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_RST;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm #(
  parameter int RST_PULSE = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic rst_en_i,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  output logic sys_rst_o,
  output logic irq_o
);
  localparam int PC_W = $clog2(RST_PULSE + 1);

  logic [PC_W-1:0] pulse_q, pulse_d;
  logic            irq_q, irq_d;

  always_comb begin
    pulse_d = pulse_q;
    if (expire_i && rst_en_i)
      pulse_d = PC_W'(RST_PULSE);
    else if (pulse_q != '0)
      pulse_d = pulse_q - 1'b1;

    irq_d = irq_q;
    if (irq_clr_i)
      irq_d = 1'b0;
    else if (expire_i && irq_en_i)
      irq_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      irq_q   <= irq_d;
    end
  end

  assign sys_rst_o = (pulse_q != '0);
  assign irq_o     = irq_q;
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int               ADDR_W       = 8,
  parameter int               CNT_W        = 16,
  parameter int               RST_PULSE    = 128,
  parameter int               DIV_MIN_LOG2 = 4,
  parameter logic [31:0]      CTRL_RST     = 32'h0000_8021,
  parameter logic [CNT_W-1:0] CNT_RST      = 16'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              sys_rst_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] cnt;
  logic             wr_ctrl, wr_reload, wr_cnt;
  logic             tick, expire;

  assign wr_ctrl   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CTRL));
  assign wr_reload = bus_we_i && (bus_addr_i == ADDR_W'(OFF_RELOAD));
  assign wr_cnt    = bus_we_i && (bus_addr_i == ADDR_W'(OFF_COUNT));

  always_comb begin
    ctrl_d   = wr_ctrl   ? ctrl_unpack(bus_wdata_i) : ctrl_q;
    reload_d = wr_reload ? bus_wdata_i[CNT_W-1:0]  : reload_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= ctrl_unpack(CTRL_RST);
      reload_q <= CNT_RST;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFF_CTRL))
      bus_rdata_o = ctrl_pack(ctrl_q);
    else if (bus_addr_i == ADDR_W'(OFF_RELOAD))
      bus_rdata_o = 32'(reload_q);
    else if (bus_addr_i == ADDR_W'(OFF_COUNT))
      bus_rdata_o = 32'(cnt);
  end

  wdog_tick_gen #(
    .PRE_W(PRE_W), .DIVSEL_W(DIVSEL_W), .DIV_MIN_LOG2(DIV_MIN_LOG2)
  ) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(ctrl_q.run), .restart_i(wr_ctrl),
    .pre_i(ctrl_q.pre), .div_sel_i(ctrl_q.div_sel),
    .tick_o(tick)
  );

  wdog_down_counter #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_i(tick), .load_i(wr_cnt),
    .load_val_i(bus_wdata_i[CNT_W-1:0]), .reload_val_i(reload_q),
    .cnt_o(cnt), .expire_o(expire)
  );

  wdog_alarm #(.RST_PULSE(RST_PULSE)) u_alarm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .expire_i(expire), .rst_en_i(ctrl_q.rst_en), .irq_en_i(ctrl_q.irq_en),
    .irq_clr_i(wr_cnt),
    .sys_rst_o(sys_rst_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk #(
  parameter int CNT_W     = 16,
  parameter int RST_PULSE = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             wr_cnt,
  input logic [CNT_W-1:0] wdata_cnt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             run,
  input logic             expire,
  input logic             rst_en,
  input logic             irq_en,
  input logic             sys_rst_o,
  input logic             irq_o
);
  logic [15:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 len_q <= '0;
    else if (expire && rst_en)   len_q <= 16'd1;
    else if (sys_rst_o)          len_q <= len_q + 16'd1;
    else                         len_q <= '0;
  end

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wr_cnt && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wr_cnt && cnt == '0) |=> (cnt == $past(reload)));
  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> (cnt == $past(wdata_cnt)));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_cnt) |=> $stable(cnt));
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> !irq_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_cnt) |=> irq_o);
  a_r9_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(expire && irq_en));
  a_r8_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(expire && rst_en));
  a_r8_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (len_q <= 16'(RST_PULSE)));
  a_r8_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (len_q == 16'(RST_PULSE + 1)));
endmodule

bind wdog_prescaled wdog_prescaled_chk #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .wr_cnt(wr_cnt),
  .wdata_cnt(bus_wdata_i[CNT_W-1:0]), .cnt(cnt), .reload(reload_q),
  .run(ctrl_q.run), .expire(expire), .rst_en(ctrl_q.rst_en),
  .irq_en(ctrl_q.irq_en), .sys_rst_o(sys_rst_o), .irq_o(irq_o)
);

// File: tb/tb_wdog_prescaled.sv
module tb_wdog_prescaled;
  logic        clk, rst_n;
  logic [7:0]  addr;
  logic        we;
  logic [31:0] wdata, rdata;
  logic        sys_rst, irq;
  int          n_chk, n_err;

  localparam logic [7:0] A_CTRL = 8'h00, A_RLD = 8'h04, A_CNT = 8'h08;

  wdog_prescaled dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sys_rst_o(sys_rst), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // measure two tick periods after a control write just made
  task automatic measure(input int exp_t, input string req);
    logic [31:0] prev, cur;
    int i;
    for (int p = 0; p < 2; p++) begin
      rd(A_CNT, prev);
      i = 0;
      cur = prev;
      while (cur == prev && i < 4 * exp_t + 8) begin
        @(negedge clk);
        i++;
        rd(A_CNT, cur);
      end
      chk(i == exp_t, req, i, exp_t);
      chk(cur == prev - 1, "R4", cur, prev - 1);
    end
  endtask

  initial begin
    logic [31:0] v;
    int hi;
    bit bad;
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk(v == 32'h8021, "R1", v, 32'h8021);
    rd(A_RLD, v);  chk(v == 32'h8000, "R1", v, 32'h8000);
    rd(A_CNT, v);  chk(v == 32'h8000, "R1", v, 32'h8000);
    chk(!sys_rst && !irq, "R1", {sys_rst, irq}, 0);

    // R2 field masking and map
    wr(A_CTRL, 32'hFFFF_FFDF);
    rd(A_CTRL, v); chk(v == 32'h0000_FF1D, "R2", v, 32'h0000_FF1D);
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'hDEAD_1234);
    rd(A_RLD, v); chk(v == 32'h1234, "R2", v, 32'h1234);
    rd(8'h0C, v); chk(v == 0, "R2", v, 0);
    wr(A_CNT, 32'h0000_00AB);
    rd(A_CNT, v); chk(v == 32'hAB, "R5", v, 32'hAB);

    // R3 sweep of prescaler and divider
    for (int ds = 0; ds < 4; ds++) begin
      for (int p = 0; p < 4; p++) begin
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'd1000);
        wr(A_CTRL, (p << 8) | (ds << 3) | 32'h20);
        measure((p + 1) * (16 << ds), "R3");
      end
    end

    // R6 control write restarts the phase
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd500);
    wr(A_CTRL, 32'h20);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h20);
    measure(16, "R6");

    // R7 stop keeps fields and freezes counter
    wr(A_CTRL, 32'h0000_0318);
    rd(A_CNT, v);
    hi = int'(v);
    repeat (300) @(negedge clk);
    rd(A_CNT, v); chk(v == hi, "R7", v, hi);
    rd(A_CTRL, v); chk(v == 32'h0318, "R7", v, 32'h0318);

    // R9 interrupt on expiry, held until counter write
    wr(A_RLD, 32'd5);
    wr(A_CNT, 32'd2);
    wr(A_CTRL, 32'h24);
    repeat (47) @(negedge clk);
    chk(!irq, "R9", irq, 0);
    @(negedge clk);
    chk(irq, "R9", irq, 1);
    rd(A_CNT, v); chk(v == 5, "R4", v, 5);
    repeat (100) @(negedge clk);
    chk(irq && !sys_rst, "R9", {irq, sys_rst}, 2);
    wr(A_CNT, 32'd7);
    chk(!irq, "R9", irq, 0);

    // R8 reset pulse length
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'd3);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h39);
    repeat (127) @(negedge clk);
    chk(!sys_rst, "R8", sys_rst, 0);
    @(negedge clk);
    chk(sys_rst, "R8", sys_rst, 1);
    hi = 0;
    while (sys_rst && hi < 400) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == 128, "R8", hi, 128);
    chk(!irq, "R9", irq, 0);

    // R9 both enables clear: expiry drives nothing
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'd9);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h20);
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (sys_rst || irq) bad = 1;
    end
    chk(!bad, "R9", bad, 0);
    rd(A_CNT, v); chk(v == 8, "R4", v, 8);

    // R10 keep-alive
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'd3);
    wr(A_CNT, 32'd3);
    wr(A_CTRL, 32'h25);
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      repeat (30) begin
        @(negedge clk);
        if (sys_rst || irq) bad = 1;
      end
      wr(A_CNT, 32'd3);
    end
    chk(!bad, "R10", bad, 0);
    wr(A_CTRL, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired, R3 run incomplete actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule